// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns single-master memory requests into strobe sequences on an external bus that serves several DRAM areas and a set of ordinary devices. A DRAM row that has been opened stays open between requests, so later requests to the same row of the same area run only their column phase. The open row also survives requests to non-DRAM devices. In that case the row strobe stays asserted and only the DRAM read and write strobes are dropped, and a later return to the same row picks up page mode again with no new row phase.

The row is closed with a precharge whenever keeping it open would be wrong. That happens when another area or another row is addressed, when a CAS-before-RAS refresh is due, or when an outside master wants the bus. The outside master receives a grant only once every strobe is idle. Requests stay in the same form until the grant is withdrawn. Non-DRAM devices are modelled as a fixed-length pass-through access.

The request address splits into three fields: the area index in the top `AREA_W` bits, the row in the middle `ROW_W` bits and the column in the low `COL_W` bits. Areas below `N_DRAM` are DRAM. All other areas are plain devices.

Top module: `dram_page_seq`

## Requirements
- R1: During and after reset every strobe is high (inactive), `bus_grant` is low, and neither done output is high.
- R2: A DRAM request with no row open drives the area's `ras_n` bit low for `RAS_CYC` cycles with the row on `ma`. It then runs `CAS_CYC` cycles with the column on `ma`, and `req_done` pulses for one cycle in the cycle after the last CAS cycle. `ras_n` stays low afterwards.
- R3: A request to the open row of the open area runs only CAS cycles. The area's `ras_n` bit never rises, and `req_done` follows after `CAS_CYC+1` cycles.
- R4: A non-DRAM request made while a row is open and its strobes are still active inserts one cycle in which `rd_n` and `wr_n` go high with `ras_n` held, ahead of an `OTH_CYC`-cycle device access. Later device requests add no further such cycle.
- R5: After such a suspension, a request to the same row re-asserts the read/write strobe in its CAS cycle with no RAS phase.
- R6: A request to a different row or a different area first raises all of `ras_n` for at least `PRE_CYC` cycles, then runs a full RAS phase on the new area.
- R7: During a non-DRAM access, `rd_n`, `wr_n`, `cas_lo_n` and `cas_hi_n` all stay high.
- R8: In a CAS cycle, `rd_n` is low for reads, and `wr_n` is low only for writes with `req_be[0]` set. `cas_lo_n` follows `req_be[0]` and `cas_hi_n` follows `req_be[1]` (bit set means that strobe is low).
- R9: A refresh request first closes any open row. It then drives both CAS strobes low one cycle before all `ras_n` bits go low, holds that state for `RAS_CYC` cycles, pulses `rfsh_done`, and precharges.
- R10: `bus_grant` rises only after the precharge and only with every strobe high. While it is high, requests are not served. They are served after `bus_req` falls.
- R11: Outside a refresh, at most one `ras_n` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; held until `req_done` |
| req_addr | input | AREA_W+ROW_W+COL_W | Area, row and column of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| refresh_req | input | 1 | Refresh wanted; held until `rfsh_done` |
| bus_req | input | 1 | Outside master asks for the bus |
| ma | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | N_DRAM | Row strobes, one per DRAM area, active low |
| cas_hi_n | output | 1 | High-byte column strobe, active low |
| cas_lo_n | output | 1 | Low-byte column strobe, active low |
| rd_n | output | 1 | DRAM read strobe, active low |
| wr_n | output | 1 | DRAM low-byte write strobe, active low |
| bus_grant | output | 1 | Bus handed to the outside master |
| req_done | output | 1 | One-cycle completion pulse for a request |
| rfsh_done | output | 1 | One-cycle pulse when the refresh row phase ends |

## Verification
A stale open-row record shows up at the ports on the very next request. A page hit then appears where a full RAS phase was due, or an extra precharge appears on a true hit, so the request latency moves by whole phases and the `ras_n` trace rises or fails to rise. A lost suspension flag appears as a missing or duplicated strobe-drop cycle, visible as a one-cycle change in device-access latency. A wrong sequencer state in refresh or bus handover shows up within a few cycles: CAS goes low without a preceding all-high precharge, or the grant rises over an active strobe.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RAS, ST_CAS, ST_PAUSE, ST_OTHER,
    ST_PRE, ST_REFC, ST_REFR, ST_GRANT
  } seq_st_e;

  typedef enum logic [2:0] {
    A_NONE, A_RAS, A_CAS, A_PAUSE, A_OTHER, A_PRE, A_REFC, A_GRANT
  } seq_act_e;
endpackage

// File: rtl/dps_decode.sv
module dps_decode #(
  parameter int AREA_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int N_DRAM = 2,
  parameter int MA_W   = 8,
  parameter int ADDR_W = AREA_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              open_vld,
  input  logic [AREA_W-1:0] open_area,
  input  logic [ROW_W-1:0]  open_row,
  output logic              is_dram,
  output logic [AREA_W-1:0] area,
  output logic [ROW_W-1:0]  row,
  output logic [MA_W-1:0]   row_ma,
  output logic [MA_W-1:0]   col_ma,
  output logic              page_hit
);
  logic [COL_W-1:0] col;

  always_comb begin
    area     = addr[ADDR_W-1 -: AREA_W];
    row      = addr[COL_W +: ROW_W];
    col      = addr[0 +: COL_W];
    is_dram  = ({{(32-AREA_W){1'b0}}, area} < N_DRAM);
    row_ma   = MA_W'(row);
    col_ma   = MA_W'(col);
    page_hit = is_dram && open_vld && (area == open_area) && (row == open_row);
  end
endmodule

// File: rtl/dps_openrow.sv
module dps_openrow #(
  parameter int AREA_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              clr,
  input  logic              susp_set,
  input  logic              susp_clr,
  input  logic [AREA_W-1:0] area_in,
  input  logic [ROW_W-1:0]  row_in,
  output logic              open_vld,
  output logic [AREA_W-1:0] open_area,
  output logic [ROW_W-1:0]  open_row,
  output logic              susp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld  <= 1'b0;
      open_area <= '0;
      open_row  <= '0;
      susp      <= 1'b0;
    end else begin
      if (set) begin
        open_vld  <= 1'b1;
        open_area <= area_in;
        open_row  <= row_in;
        susp      <= 1'b0;
      end else if (clr) begin
        open_vld <= 1'b0;
        susp     <= 1'b0;
      end else if (susp_set) begin
        susp <= 1'b1;
      end else if (susp_clr) begin
        susp <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
#(
  parameter int AREA_W  = 2,
  parameter int N_DRAM  = 2,
  parameter int MA_W    = 8,
  parameter int RAS_CYC = 2,
  parameter int CAS_CYC = 1,
  parameter int PRE_CYC = 2,
  parameter int OTH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic              refresh_req,
  input  logic              bus_req,
  input  logic              is_dram,
  input  logic [AREA_W-1:0] area,
  input  logic [MA_W-1:0]   row_ma,
  input  logic [MA_W-1:0]   col_ma,
  input  logic              page_hit,
  input  logic              open_vld,
  input  logic              susp,
  output logic [MA_W-1:0]   ma,
  output logic [N_DRAM-1:0] ras_n,
  output logic              cas_hi_n,
  output logic              cas_lo_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_grant,
  output logic              req_done,
  output logic              rfsh_done,
  output logic              open_set,
  output logic              open_clr,
  output logic              susp_set,
  output logic              susp_clr
);
  localparam int MAX_RC = (RAS_CYC > CAS_CYC) ? RAS_CYC : CAS_CYC;
  localparam int MAX_PO = (PRE_CYC > OTH_CYC) ? PRE_CYC : OTH_CYC;
  localparam int MAXC   = (MAX_RC > MAX_PO) ? MAX_RC : MAX_PO;
  localparam int CNT_W  = $clog2(MAXC + 1);

  seq_st_e          st_q;
  seq_act_e         act;
  logic [CNT_W-1:0] cnt_q;

  // Decision taken in idle; priority: bus release, refresh, request.
  always_comb begin
    act = A_NONE;
    if (st_q == ST_IDLE) begin
      if (bus_req)          act = open_vld ? A_PRE : A_GRANT;
      else if (refresh_req) act = open_vld ? A_PRE : A_REFC;
      else if (req_valid) begin
        if (is_dram)        act = page_hit ? A_CAS : (open_vld ? A_PRE : A_RAS);
        else                act = (open_vld && !susp) ? A_PAUSE : A_OTHER;
      end
    end
    open_set = (act == A_RAS);
    open_clr = (act == A_PRE);
    susp_set = (act == A_PAUSE);
    susp_clr = (act == A_CAS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      ma        <= '0;
      ras_n     <= '1;
      cas_hi_n  <= 1'b1;
      cas_lo_n  <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      bus_grant <= 1'b0;
      req_done  <= 1'b0;
      rfsh_done <= 1'b0;
    end else begin
      req_done  <= 1'b0;
      rfsh_done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          case (act)
            A_RAS: begin
              ras_n <= ~(N_DRAM'(1) << area);
              ma    <= row_ma;
              cnt_q <= CNT_W'(RAS_CYC - 1);
              st_q  <= ST_RAS;
            end
            A_CAS: begin
              ma       <= col_ma;
              cas_lo_n <= ~req_be[0];
              cas_hi_n <= ~req_be[1];
              rd_n     <= req_write;
              wr_n     <= ~(req_write & req_be[0]);
              cnt_q    <= CNT_W'(CAS_CYC - 1);
              st_q     <= ST_CAS;
            end
            A_PAUSE: begin
              rd_n <= 1'b1;
              wr_n <= 1'b1;
              st_q <= ST_PAUSE;
            end
            A_OTHER: begin
              ma    <= col_ma;
              cnt_q <= CNT_W'(OTH_CYC - 1);
              st_q  <= ST_OTHER;
            end
            A_PRE: begin
              ras_n <= '1;
              rd_n  <= 1'b1;
              wr_n  <= 1'b1;
              cnt_q <= CNT_W'(PRE_CYC - 1);
              st_q  <= ST_PRE;
            end
            A_REFC: begin
              cas_lo_n <= 1'b0;
              cas_hi_n <= 1'b0;
              st_q     <= ST_REFC;
            end
            A_GRANT: begin
              bus_grant <= 1'b1;
              st_q      <= ST_GRANT;
            end
            default: ;
          endcase
        end
        ST_RAS: begin
          if (cnt_q == '0) begin
            ma       <= col_ma;
            cas_lo_n <= ~req_be[0];
            cas_hi_n <= ~req_be[1];
            rd_n     <= req_write;
            wr_n     <= ~(req_write & req_be[0]);
            cnt_q    <= CNT_W'(CAS_CYC - 1);
            st_q     <= ST_CAS;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_CAS: begin
          if (cnt_q == '0) begin
            cas_lo_n <= 1'b1;
            cas_hi_n <= 1'b1;
            req_done <= 1'b1;
            st_q     <= ST_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_PAUSE: begin
          ma    <= col_ma;
          cnt_q <= CNT_W'(OTH_CYC - 1);
          st_q  <= ST_OTHER;
        end
        ST_OTHER: begin
          if (cnt_q == '0) begin
            req_done <= 1'b1;
            st_q     <= ST_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_PRE: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_REFC: begin
          ras_n <= '0;
          cnt_q <= CNT_W'(RAS_CYC - 1);
          st_q  <= ST_REFR;
        end
        ST_REFR: begin
          if (cnt_q == '0) begin
            ras_n     <= '1;
            cas_lo_n  <= 1'b1;
            cas_hi_n  <= 1'b1;
            rfsh_done <= 1'b1;
            cnt_q     <= CNT_W'(PRE_CYC - 1);
            st_q      <= ST_PRE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_GRANT: begin
          if (!bus_req) begin
            bus_grant <= 1'b0;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Run of consecutive all-high row-strobe cycles, saturating at PRE_CYC.
  logic [CNT_W:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst) hi_run <= (CNT_W+1)'(PRE_CYC);
    else if (&ras_n) hi_run <= (hi_run >= (CNT_W+1)'(PRE_CYC)) ? hi_run : hi_run + 1'b1;
    else hi_run <= '0;
  end

  assert_pre_len_R6: assert property (@(posedge clk) disable iff (rst)
    ((&$past(ras_n)) && !(&ras_n)) |-> ($past(hi_run) >= (CNT_W+1)'(PRE_CYC)));
  assert_grant_idle_R10: assert property (@(posedge clk) disable iff (rst)
    bus_grant |-> ((&ras_n) && cas_lo_n && cas_hi_n && rd_n && wr_n));
  assert_other_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OTHER) |-> (rd_n && wr_n && cas_lo_n && cas_hi_n));
  assert_one_row_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_REFR) |-> ($countones(~ras_n) <= 1));
  assert_cas_first_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REFR && $past(st_q) == ST_REFC) |->
      ($past(!cas_lo_n && !cas_hi_n) && (&$past(ras_n))));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int AREA_W  = 2,
  parameter int ROW_W   = 8,
  parameter int COL_W   = 8,
  parameter int N_DRAM  = 2,
  parameter int RAS_CYC = 2,
  parameter int CAS_CYC = 1,
  parameter int PRE_CYC = 2,
  parameter int OTH_CYC = 2,
  parameter int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int ADDR_W  = AREA_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic              refresh_req,
  input  logic              bus_req,
  output logic [MA_W-1:0]   ma,
  output logic [N_DRAM-1:0] ras_n,
  output logic              cas_hi_n,
  output logic              cas_lo_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_grant,
  output logic              req_done,
  output logic              rfsh_done
);
  logic              is_dram, page_hit, open_vld, susp;
  logic              open_set, open_clr, susp_set, susp_clr;
  logic [AREA_W-1:0] area, open_area;
  logic [ROW_W-1:0]  row, open_row;
  logic [MA_W-1:0]   row_ma, col_ma;

  dps_decode #(.AREA_W(AREA_W), .ROW_W(ROW_W), .COL_W(COL_W), .N_DRAM(N_DRAM),
               .MA_W(MA_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .open_vld(open_vld), .open_area(open_area), .open_row(open_row),
    .is_dram(is_dram), .area(area), .row(row), .row_ma(row_ma), .col_ma(col_ma),
    .page_hit(page_hit));

  dps_openrow #(.AREA_W(AREA_W), .ROW_W(ROW_W)) u_open (
    .clk(clk), .rst(rst), .set(open_set), .clr(open_clr), .susp_set(susp_set),
    .susp_clr(susp_clr), .area_in(area), .row_in(row), .open_vld(open_vld),
    .open_area(open_area), .open_row(open_row), .susp(susp));

  dps_fsm #(.AREA_W(AREA_W), .N_DRAM(N_DRAM), .MA_W(MA_W), .RAS_CYC(RAS_CYC),
            .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC), .OTH_CYC(OTH_CYC)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_be(req_be),
    .refresh_req(refresh_req), .bus_req(bus_req), .is_dram(is_dram), .area(area),
    .row_ma(row_ma), .col_ma(col_ma), .page_hit(page_hit), .open_vld(open_vld),
    .susp(susp), .ma(ma), .ras_n(ras_n), .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_grant(bus_grant), .req_done(req_done),
    .rfsh_done(rfsh_done), .open_set(open_set), .open_clr(open_clr),
    .susp_set(susp_set), .susp_clr(susp_clr));
endmodule

// File: tb/sim_dram_page_seq.sv
`timescale 1ns/1ps
module sim_dram_page_seq;
  localparam int AREA_W = 2, ROW_W = 8, COL_W = 8, N_DRAM = 2;
  localparam int RAS_CYC = 2, CAS_CYC = 1, PRE_CYC = 2, OTH_CYC = 2;
  localparam int MA_W = 8, ADDR_W = AREA_W + ROW_W + COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0, bus_req = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_be = 2'b11;
  logic [MA_W-1:0] ma;
  logic [N_DRAM-1:0] ras_n;
  logic cas_hi_n, cas_lo_n, rd_n, wr_n, bus_grant, req_done, rfsh_done;

  always #5 clk = ~clk;

  dram_page_seq #(.AREA_W(AREA_W), .ROW_W(ROW_W), .COL_W(COL_W), .N_DRAM(N_DRAM),
    .RAS_CYC(RAS_CYC), .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC), .OTH_CYC(OTH_CYC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_be(req_be), .refresh_req(refresh_req), .bus_req(bus_req), .ma(ma), .ras_n(ras_n),
    .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_grant(bus_grant), .req_done(req_done), .rfsh_done(rfsh_done));

  int total = 0, bad = 0;
  int lat, ras_only, pre_hi, cas_cnt, strobe_low, row_seen, col_seen;
  logic [N_DRAM-1:0] ras_or;
  logic rd_at, wr_at, clo_at, chi_at, f_rd, f_cas_idle;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    chk("watchdog", 1, 0);
    finish_run();
  end

  function automatic logic [ADDR_W-1:0] mk(input int a, input int r, input int c);
    return {AREA_W'(a), ROW_W'(r), COL_W'(c)};
  endfunction

  // Samples each cycle after the request is driven, until req_done.
  task automatic collect();
    bit seen_cas = 0, done = 0;
    lat = 0; ras_only = 0; pre_hi = 0; cas_cnt = 0; strobe_low = 0;
    row_seen = -1; col_seen = -1; ras_or = '0;
    rd_at = 1; wr_at = 1; clo_at = 1; chi_at = 1; f_rd = 0; f_cas_idle = 0;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
      ras_or |= ras_n;
      if (lat == 1) begin f_rd = rd_n; f_cas_idle = cas_lo_n & cas_hi_n; end
      if (!(cas_lo_n && cas_hi_n)) begin
        cas_cnt++;
        if (!seen_cas) begin
          seen_cas = 1; col_seen = int'(ma);
          rd_at = rd_n; wr_at = wr_n; clo_at = cas_lo_n; chi_at = cas_hi_n;
        end
      end else if (!seen_cas) begin
        if (&ras_n) pre_hi++;
        else begin
          if (ras_only == 0) row_seen = int'(ma);
          ras_only++;
        end
      end
      if (!(rd_n && wr_n)) strobe_low++;
      if (req_done) done = 1;
    end
    req_valid = 0;
    if (!done) chk("request timeout", 0, 1);
  endtask

  task automatic access(input int a, input int r, input int c, input bit we, input logic [1:0] be);
    req_addr = mk(a, r, c); req_write = we; req_be = be; req_valid = 1;
    collect();
  endtask

  task automatic t_reset();
    chk("R1 ras_n idle", int'(ras_n), 3);
    chk("R1 cas idle", int'(cas_lo_n & cas_hi_n), 1);
    chk("R1 rd/wr idle", int'(rd_n & wr_n), 1);
    chk("R1 grant low", int'(bus_grant), 0);
    chk("R1 done low", int'(req_done | rfsh_done), 0);
  endtask

  task automatic t_first_read();
    access(0, 8'h12, 8'h34, 0, 2'b11);
    chk("R2 latency", lat, RAS_CYC + CAS_CYC + 1);
    chk("R2 ras cycles", ras_only, RAS_CYC);
    chk("R2 cas cycles", cas_cnt, CAS_CYC);
    chk("R2 row on ma", row_seen, 8'h12);
    chk("R2 col on ma", col_seen, 8'h34);
    chk("R8 rd low on read", int'(rd_at), 0);
    chk("R8 wr high on read", int'(wr_at), 1);
    @(negedge clk);
    chk("R2 row stays open", int'(ras_n), 2);
    chk("R2 done is a pulse", int'(req_done), 0);
  endtask

  task automatic t_hit_writes();
    access(0, 8'h12, 8'h35, 1, 2'b01);
    chk("R3 hit latency", lat, CAS_CYC + 1);
    chk("R3 ras held", int'(ras_or[0]), 0);
    chk("R8 wr low for low byte", int'(wr_at), 0);
    chk("R8 cas_lo low", int'(clo_at), 0);
    chk("R8 cas_hi high", int'(chi_at), 1);
    access(0, 8'h12, 8'h36, 1, 2'b10);
    chk("R8 wr high for high byte only", int'(wr_at), 1);
    chk("R8 cas_hi low", int'(chi_at), 0);
    chk("R8 cas_lo high", int'(clo_at), 1);
    access(0, 8'h12, 8'h37, 0, 2'b11);
    chk("R3 read hit latency", lat, CAS_CYC + 1);
    chk("R3 read hit ras held", int'(ras_or[0]), 0);
  endtask

  task automatic t_other();
    chk("R4 rd active before", int'(rd_n), 0);
    access(2, 8'h00, 8'h11, 0, 2'b11);
    chk("R4 paused latency", lat, 1 + OTH_CYC + 1);
    chk("R4 strobe drop first", int'(f_rd), 1);
    chk("R4 ras held", int'(ras_or[0]), 0);
    chk("R7 no cas on device", cas_cnt, 0);
    chk("R7 no rd/wr on device", strobe_low, 0);
    access(3, 8'h00, 8'h22, 1, 2'b11);
    chk("R4 no second pause", lat, OTH_CYC + 1);
    chk("R7 no strobes on write", strobe_low + cas_cnt, 0);
  endtask

  task automatic t_resume();
    access(0, 8'h12, 8'h40, 0, 2'b11);
    chk("R5 resume latency", lat, CAS_CYC + 1);
    chk("R5 no ras phase", int'(ras_or[0]), 0);
    chk("R5 rd re-asserted", int'(rd_at), 0);
  endtask

  task automatic t_row_miss();
    access(0, 8'h13, 8'h01, 0, 2'b11);
    chk("R6 row miss latency", lat, PRE_CYC + 1 + RAS_CYC + CAS_CYC + 1);
    chk("R6 precharge length", int'(pre_hi >= PRE_CYC), 1);
    chk("R6 new ras phase", ras_only, RAS_CYC);
    chk("R6 new row on ma", row_seen, 8'h13);
    access(1, 8'h13, 8'h02, 0, 2'b11);
    chk("R6 area change latency", lat, PRE_CYC + 1 + RAS_CYC + CAS_CYC + 1);
    chk("R11 only area1 open", int'(ras_n), 1);
  endtask

  task automatic t_refresh();
    int n = 0, pre = 0, both = 0;
    bit seen_c = 0, got = 0, first_ok = 0;
    refresh_req = 1;
    while (!got && n < 60) begin
      @(negedge clk);
      n++;
      if (!seen_c && !cas_lo_n && !cas_hi_n) begin seen_c = 1; first_ok = &ras_n; end
      if (!seen_c && (&ras_n)) pre++;
      if (~|ras_n && !cas_lo_n && !cas_hi_n) both++;
      if (rfsh_done) got = 1;
    end
    refresh_req = 0;
    chk("R9 refresh acknowledged", int'(got), 1);
    chk("R9 row closed first", int'(pre >= PRE_CYC), 1);
    chk("R9 cas before ras", int'(first_ok), 1);
    chk("R9 ras held length", both, RAS_CYC);
    repeat (PRE_CYC + 2) @(negedge clk);
    chk("R9 strobes idle after", int'((&ras_n) & cas_lo_n & cas_hi_n & rd_n & wr_n), 1);
    access(1, 8'h13, 8'h03, 0, 2'b11);
    chk("R9 row reopened", ras_only, RAS_CYC);
  endtask

  task automatic t_bus();
    int n = 0, pre = 0;
    bit quiet = 1;
    access(0, 8'h05, 8'h00, 0, 2'b11);
    bus_req = 1;
    while (!bus_grant && n < 40) begin
      @(negedge clk);
      n++;
      if (!bus_grant && (&ras_n)) pre++;
    end
    chk("R10 grant given", int'(bus_grant), 1);
    chk("R10 precharge before grant", int'(pre >= PRE_CYC), 1);
    chk("R10 strobes idle at grant", int'((&ras_n) & cas_lo_n & cas_hi_n & rd_n & wr_n), 1);
    req_addr = mk(0, 8'h05, 8'h01); req_write = 0; req_be = 2'b11; req_valid = 1;
    repeat (6) begin
      @(negedge clk);
      if (req_done || !bus_grant || !(&ras_n)) quiet = 0;
    end
    chk("R10 request stalled", int'(quiet), 1);
    bus_req = 0;
    collect();
    chk("R10 served after release", ras_only, RAS_CYC);
    chk("R10 grant dropped", int'(bus_grant), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_first_read();
    t_hit_writes();
    t_other();
    t_resume();
    t_row_miss();
    t_refresh();
    t_bus();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule